// File: doc/BRIEF.md
# Triggered Pulse Delay Bank

This block is a bank of independent delay channels. All channels listen to the same small set of trigger inputs. Each channel has its own selector that picks one input and its own enable bit. It also holds an 8-bit delay count. When the chosen input rises while the channel is enabled, the channel waits the programmed number of clock periods and then drives a single-cycle pulse on its own output. With a 200 MHz clock, one count is 5 ns, so the delay spans 0 to 1.275 µs.

Each channel is programmed and observed through one 16-bit register on a simple synchronous bus. The register holds the delay, the input choice and the enable bit. It also has a read-only flag that stays set once the channel has accepted a trigger. Writing the register reprograms the channel. The write also clears the flag and aborts any delay that is counting. The registers sit at consecutive even byte addresses. Trigger inputs are treated as asynchronous and pass through a synchronizer before edge detection.

Top module: `trig_delay_bank`

## Requirements
- R1: After reset every channel register reads 0x0000 (disabled, delay 0, input 0 selected, flag clear) and every trig_out bit is 0.
- R2: Register fields are: bits 7:0 delay count, bits 9:8 input select, bit 10 enable, bit 11 detect flag. Bits 15:12 always read 0, and the value written to bit 11 is ignored. Writing 0xFFFF therefore reads back 0x07FF.
- R3: Channel i is at byte address 0x20 + 2*i, for i from 0 to 9. Reads of any other address (odd, below 0x20, or above 0x32) return 0, and writes to them change no channel.
- R4: Select value k connects trigger input k (k = 0..3) to the channel. Edges on the other inputs produce no pulse and do not set the flag.
- R5: A rising edge on an enabled channel's selected input, driven between clock edges, produces a pulse on that channel's trig_out. The pulse is exactly one cycle wide and high in the cycle after clock edge number D+3 counted from the input change: two synchronizer stages, one detect stage, then D counts. For D=0 this is the cycle right after detection; D=255 is also supported.
- R6: A channel with its enable bit at 0 produces no pulse and does not set its flag.
- R7: An accepted trigger sets the channel's detect flag (bit 11). The flag stays set until the channel register is written.
- R8: A rising edge that arrives while the channel's delay is still counting is ignored. Only one pulse results.
- R9: A write to a channel register clears its flag, aborts any delay in progress (no pulse), and loads the new fields. If the write and a trigger detection fall in the same cycle, the write wins.
- R10: rd_data is registered. It shows the addressed register one cycle after rd_en is sampled high, and reads 0 in a cycle that follows rd_en low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one delay count per period |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_in | input | 4 | Shared asynchronous trigger inputs |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte address of the register |
| wdata | input | 16 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_data | output | 16 | Registered read data |
| trig_out | output | 10 | One delayed pulse output per channel |

## Verification
Two things can land in the same clock edge: a register write to a channel, and the detection of a trigger edge on that same channel. The bench raises the selected input and then places the write strobe so that it is sampled on exactly the edge at which the synchronized input's rise is detected. The outcome is judged at the ports. No pulse may appear, because the scoreboard holds no expectation for one. A read-back must then show the new configuration with the detect flag clear.

// File: rtl/tdb_pkg.sv
package tdb_pkg;
   localparam int HWORD_W = 16;
   typedef logic [HWORD_W-1:0] hword_t;

   // Byte address of channel idx within the register window
   function automatic int chan_byte_addr(input int base, input int idx);
      return base + 2 * idx;
   endfunction
endpackage

// File: rtl/tdb_sync.sv
module tdb_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 0) begin : g_bad
      $error("tdb_sync: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_bypass
      assign q = d;
   end else begin : g_chain
      logic [WIDTH-1:0] stage_q [STAGES];
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
         end else begin
            stage_q[0] <= d;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
         end
      end
      assign q = stage_q[STAGES-1];
   end
endmodule

// File: rtl/tdb_regfile.sv
module tdb_regfile
   import tdb_pkg::*;
#(
   parameter int NUM_CH    = 10,
   parameter int ADDR_W    = 8,
   parameter int BASE_ADDR = 32
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic                      rd_en,
   input  logic [ADDR_W-1:0]         addr,
   input  logic [NUM_CH*HWORD_W-1:0] ch_rdata,
   output logic [NUM_CH-1:0]         wr_hit,
   output hword_t                    rd_data
);
   localparam int LAST_ADDR = BASE_ADDR + 2 * (NUM_CH - 1);

   if (LAST_ADDR >= (1 << ADDR_W)) begin : g_bad_span
      $error("tdb_regfile: register window exceeds address space");
   end
   if (BASE_ADDR % 2 != 0) begin : g_bad_align
      $error("tdb_regfile: BASE_ADDR must be halfword aligned");
   end

   logic [NUM_CH-1:0] addr_match;
   hword_t            rd_mux;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
      localparam logic [ADDR_W-1:0] CH_ADDR = ADDR_W'(chan_byte_addr(BASE_ADDR, i));
      assign addr_match[i] = (addr == CH_ADDR);
      assign wr_hit[i]     = wr_en & addr_match[i];
   end

   always_comb begin
      rd_mux = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (addr_match[i]) rd_mux = ch_rdata[i*HWORD_W +: HWORD_W];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     rd_data <= '0;
      else if (rd_en) rd_data <= rd_mux;
      else            rd_data <= '0;
   end
endmodule

// File: rtl/tdb_channel.sv
module tdb_channel
   import tdb_pkg::*;
#(
   parameter int NUM_IN = 4,
   parameter int SEL_W  = 2,
   parameter int DLY_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_IN-1:0] trig_sync,
   input  logic              wr_hit,
   input  hword_t            wdata,
   output hword_t            reg_view,
   output logic              pulse,
   output logic              det_flag,
   output logic              enabled
);
   localparam int SEL_LSB = DLY_W;
   localparam int EN_BIT  = DLY_W + SEL_W;
   localparam int DET_BIT = EN_BIT + 1;
   localparam int PAD_W   = HWORD_W - DET_BIT - 1;

   if (PAD_W < 0) begin : g_bad_fields
      $error("tdb_channel: fields do not fit in a halfword");
   end
   if ((1 << SEL_W) < NUM_IN) begin : g_bad_sel
      $error("tdb_channel: select field too narrow for NUM_IN");
   end

   logic [DLY_W-1:0] dly_q, cnt_q;
   logic [SEL_W-1:0] sel_q;
   logic             en_q, prev_q, busy_q, flag_q, pulse_q;
   logic             cur_val, new_val, accept;

   logic [SEL_W-1:0] wr_sel;
   assign wr_sel = wdata[SEL_LSB +: SEL_W];

   // Input selectors for the held and the incoming select values
   always_comb begin
      cur_val = 1'b0;
      new_val = 1'b0;
      for (int k = 0; k < NUM_IN; k++) begin
         if (sel_q  == SEL_W'(k)) cur_val = trig_sync[k];
         if (wr_sel == SEL_W'(k)) new_val = trig_sync[k];
      end
   end

   assign accept = en_q & cur_val & ~prev_q & ~busy_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dly_q   <= '0;
         sel_q   <= '0;
         en_q    <= 1'b0;
         prev_q  <= 1'b0;
         busy_q  <= 1'b0;
         cnt_q   <= '0;
         flag_q  <= 1'b0;
         pulse_q <= 1'b0;
      end else if (wr_hit) begin
         dly_q   <= wdata[DLY_W-1:0];
         sel_q   <= wr_sel;
         en_q    <= wdata[EN_BIT];
         prev_q  <= new_val;
         busy_q  <= 1'b0;
         cnt_q   <= '0;
         flag_q  <= 1'b0;
         pulse_q <= 1'b0;
      end else begin
         prev_q  <= cur_val;
         pulse_q <= 1'b0;
         if (accept) begin
            flag_q <= 1'b1;
            if (dly_q == '0) begin
               pulse_q <= 1'b1;
            end else begin
               busy_q <= 1'b1;
               cnt_q  <= dly_q;
            end
         end else if (busy_q) begin
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == DLY_W'(1)) begin
               pulse_q <= 1'b1;
               busy_q  <= 1'b0;
            end
         end
      end
   end

   if (PAD_W > 0) begin : g_pad
      assign reg_view = {{PAD_W{1'b0}}, flag_q, en_q, sel_q, dly_q};
   end else begin : g_nopad
      assign reg_view = {flag_q, en_q, sel_q, dly_q};
   end

   assign pulse    = pulse_q;
   assign det_flag = flag_q;
   assign enabled  = en_q;
endmodule

// File: rtl/trig_delay_bank.sv
module trig_delay_bank
   import tdb_pkg::*;
#(
   parameter int NUM_CH      = 10,
   parameter int NUM_IN      = 4,
   parameter int DLY_W       = 8,
   parameter int ADDR_W      = 8,
   parameter int BASE_ADDR   = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_IN-1:0] trig_in,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [15:0]       wdata,
   input  logic              rd_en,
   output logic [15:0]       rd_data,
   output logic [NUM_CH-1:0] trig_out
);
   localparam int SEL_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1;

   if (NUM_CH < 1) begin : g_bad_ch
      $error("trig_delay_bank: NUM_CH must be at least 1");
   end
   if (NUM_IN < 2) begin : g_bad_in
      $error("trig_delay_bank: NUM_IN must be at least 2");
   end
   if (DLY_W < 1) begin : g_bad_dly
      $error("trig_delay_bank: DLY_W must be at least 1");
   end

   logic [NUM_IN-1:0]         trig_sync;
   logic [NUM_CH-1:0]         wr_hit;
   logic [NUM_CH-1:0]         det_flag;
   logic [NUM_CH-1:0]         ch_en;
   logic [NUM_CH*HWORD_W-1:0] ch_rdata;

   tdb_sync #(
      .WIDTH (NUM_IN),
      .STAGES(SYNC_STAGES)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (trig_in),
      .q    (trig_sync)
   );

   tdb_regfile #(
      .NUM_CH   (NUM_CH),
      .ADDR_W   (ADDR_W),
      .BASE_ADDR(BASE_ADDR)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .rd_en   (rd_en),
      .addr    (addr),
      .ch_rdata(ch_rdata),
      .wr_hit  (wr_hit),
      .rd_data (rd_data)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      tdb_channel #(
         .NUM_IN(NUM_IN),
         .SEL_W (SEL_W),
         .DLY_W (DLY_W)
      ) u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .trig_sync(trig_sync),
         .wr_hit   (wr_hit[i]),
         .wdata    (wdata),
         .reg_view (ch_rdata[i*HWORD_W +: HWORD_W]),
         .pulse    (trig_out[i]),
         .det_flag (det_flag[i]),
         .enabled  (ch_en[i])
      );
   end
endmodule

// File: rtl/trig_delay_bank_chk.sv
module trig_delay_bank_chk #(
   parameter int NUM_CH = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_en,
   input logic [15:0]       rd_data,
   input logic [NUM_CH-1:0] trig_out,
   input logic [NUM_CH-1:0] wr_hit,
   input logic [NUM_CH-1:0] det_flag,
   input logic [NUM_CH-1:0] ch_en
);
   // R10: idle read port returns zero
   a_r10_idle_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> (rd_data == 16'h0000));

   // R3: at most one channel decoded per write
   a_r3_single_decode: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_hit));

   for (genvar i = 0; i < NUM_CH; i++) begin : g_per_ch
      // R5: pulse lasts one cycle
      a_r5_one_cycle_pulse: assert property (@(posedge clk) disable iff (!rst_n)
         trig_out[i] |=> !trig_out[i]);

      // R6: disabled channel stays quiet
      a_r6_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
         !ch_en[i] |=> !trig_out[i]);

      // R7: flag holds until written
      a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
         (det_flag[i] && !wr_hit[i]) |=> det_flag[i]);

      // R9: write clears flag and kills pending pulse
      a_r9_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
         wr_hit[i] |=> (!det_flag[i] && !trig_out[i]));
   end
endmodule

bind trig_delay_bank trig_delay_bank_chk #(.NUM_CH(NUM_CH)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .rd_en   (rd_en),
   .rd_data (rd_data),
   .trig_out(trig_out),
   .wr_hit  (wr_hit),
   .det_flag(det_flag),
   .ch_en   (ch_en)
);

// File: tb/trig_delay_bank_tb.sv
module trig_delay_bank_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NCH        = 10;
   localparam int NIN        = 4;
   localparam int WATCHDOG   = 50000;

   typedef struct { int ch; int cyc; } exp_t;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NIN-1:0] trig_in = '0;
   logic           wr_en = 1'b0;
   logic [7:0]     addr = '0;
   logic [15:0]    wdata = '0;
   logic           rd_en = 1'b0;
   logic [15:0]    rd_data;
   logic [NCH-1:0] trig_out;

   int   cyc = 0;
   int   checks = 0;
   int   fails = 0;
   bit   mon_on = 1'b0;
   exp_t exp_q[$];

   trig_delay_bank u_dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .trig_in (trig_in),
      .wr_en   (wr_en),
      .addr    (addr),
      .wdata   (wdata),
      .rd_en   (rd_en),
      .rd_data (rd_data),
      .trig_out(trig_out)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [7:0] ch_addr(input int ch);
      return 8'(32 + 2 * ch);
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic expect_pulse(input int ch, input int dly);
      exp_t e;
      e.ch  = ch;
      e.cyc = cyc + 3 + dly;
      exp_q.push_back(e);
   endtask

   task automatic bus_wr(input logic [7:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic bus_rd(input logic [7:0] a, input logic [15:0] exp, input string req);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      check(rd_data == exp, req, rd_data, exp);
   endtask

   // Drive input high at a negedge (caller pushes expectations right after the call starts)
   task automatic raise(input int inp);
      @(negedge clk);
      trig_in[inp] = 1'b1;
   endtask

   task automatic drop_after(input int inp, input int n);
      repeat (n) @(negedge clk);
      trig_in[inp] = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   // Scoreboard monitor
   always @(negedge clk) begin
      if (mon_on) begin
         for (int ch = 0; ch < NCH; ch++) begin
            if (trig_out[ch]) begin
               int idx;
               idx = -1;
               for (int k = 0; k < exp_q.size(); k++)
                  if (exp_q[k].ch == ch && exp_q[k].cyc == cyc) idx = k;
               checks++;
               if (idx < 0) begin
                  fails++;
                  $display("FAIL R5/R6/R8/R9: unexpected pulse ch %0d cycle %0d actual 1 expected 0", ch, cyc);
               end else begin
                  exp_q.delete(idx);
               end
            end
         end
         for (int k = exp_q.size() - 1; k >= 0; k--) begin
            if (exp_q[k].cyc < cyc) begin
               checks++;
               fails++;
               $display("FAIL R5: missing pulse ch %0d at cycle %0d actual 0 expected 1", exp_q[k].ch, exp_q[k].cyc);
               exp_q.delete(k);
            end
         end
      end
   end

   task automatic run_all();
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      mon_on = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(trig_out == '0, "R1", trig_out, 0);
      for (int ch = 0; ch < NCH; ch++) bus_rd(ch_addr(ch), 16'h0000, "R1");

      // R2/R5/R7: ch0 enabled, input 0, delay 0
      bus_wr(ch_addr(0), 16'h0400);
      bus_rd(ch_addr(0), 16'h0400, "R2");
      raise(0); expect_pulse(0, 0);
      drop_after(0, 6);
      bus_rd(ch_addr(0), 16'h0C00, "R7");

      // R4/R6: ch1 input 2 delay 5 enabled; ch2 input 2 delay 5 disabled
      bus_wr(ch_addr(1), 16'h0605);
      bus_wr(ch_addr(2), 16'h0205);
      raise(1);
      drop_after(1, 10);
      bus_rd(ch_addr(1), 16'h0605, "R4");
      raise(2); expect_pulse(1, 5);
      drop_after(2, 12);
      bus_rd(ch_addr(2), 16'h0205, "R6");
      bus_rd(ch_addr(1), 16'h0E05, "R7");

      // R8: second edge during a 20-count delay is ignored
      bus_wr(ch_addr(3), 16'h0714);
      raise(3); expect_pulse(3, 20);
      drop_after(3, 3);
      raise(3);
      drop_after(3, 3);
      repeat (25) @(negedge clk);
      raise(3); expect_pulse(3, 20);
      drop_after(3, 3);
      repeat (25) @(negedge clk);

      // R9: write clears flag; write aborts running delay
      bus_wr(ch_addr(0), 16'h0400);
      bus_rd(ch_addr(0), 16'h0400, "R9");
      raise(3);
      repeat (8) @(negedge clk);
      bus_wr(ch_addr(3), 16'h0714);
      trig_in[3] = 1'b0;
      repeat (30) @(negedge clk);
      bus_rd(ch_addr(3), 16'h0714, "R9");

      // R9: write sampled on the same edge as detection wins
      raise(0);
      @(negedge clk);
      @(negedge clk);
      wr_en = 1'b1; addr = ch_addr(0); wdata = 16'h0400;
      @(negedge clk);
      wr_en = 1'b0;
      drop_after(0, 4);
      bus_rd(ch_addr(0), 16'h0400, "R9");

      // R2: masked bits
      bus_wr(ch_addr(4), 16'hFFFF);
      bus_rd(ch_addr(4), 16'h07FF, "R2");
      bus_wr(ch_addr(4), 16'h0000);

      // R3: address decode
      bus_wr(8'h21, 16'h0000);
      bus_rd(ch_addr(0), 16'h0400, "R3");
      bus_rd(8'h21, 16'h0000, "R3");
      bus_wr(8'h34, 16'h0555);
      bus_rd(8'h34, 16'h0000, "R3");
      bus_wr(8'h1E, 16'h0555);
      bus_rd(8'h1E, 16'h0000, "R3");
      bus_wr(ch_addr(9), 16'h0301);
      bus_rd(ch_addr(9), 16'h0301, "R3");

      // R10: port reads zero while idle
      @(negedge clk);
      check(rd_data == 16'h0000, "R10", rd_data, 0);

      // R5: max delay on ch9 alongside zero delay on ch0
      bus_wr(ch_addr(9), 16'h04FF);
      raise(0); expect_pulse(0, 0); expect_pulse(9, 255);
      drop_after(0, 4);
      repeat (270) @(negedge clk);
      check(exp_q.size() == 0, "R5", exp_q.size(), 0);
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (WATCHDOG) @(posedge clk);
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      disable fork;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule